// File: doc/BRIEF.md
# Hot-Plug Slot Register Controller

This block holds the slot control and slot status register pair of a downstream or root port that supports native hot-plug. A configuration port writes either register 16 bits at a time, with one enable per byte. The slot side supplies a card-insertion pulse and an attention-button pulse. The block drives slot power, the data-link-active flag, and a hot-plug interrupt. The interrupt is either a level wire or a one-cycle message pulse that carries a vector number. The block also drives a removal strobe, and an error pulse when an unplug request is refused.

A small state machine sequences every write to slot control. It has two states. ST_IDLE waits for a control write and moves to ST_CMD when one arrives. ST_CMD applies the deferred effects of that write: it toggles the interlock, performs a power-off removal if one is due, and sets command-completed. From ST_CMD the machine returns to ST_IDLE, or stays in ST_CMD when another control write arrives in that cycle. Status event bits are write-one-to-clear. The interrupt is raised or messaged only when the combined event condition changes.

Top module: `hp_slot_ctrl`

## Requirements
- R1: The interrupt condition is true when control bit 5 (interrupt enable) is set and at least one event pair has both bits set. The pairs, as status bit / control enable bit, are 0/0 button, 1/1 power fault, 2/2 sensor change, 3/3 presence change, 4/4 command completed and 8/12 link-state change.
- R2: The interrupt state is registered one cycle after the condition changes. With `msg_mode_i` low, `intx_o` equals the registered state. With `msg_mode_i` high, `intx_o` stays low, and each change of the condition produces a one-cycle `msg_valid_o` that carries the `vec_i` value sampled at that change.
- R3: A status write clears the event bits 0, 1, 2, 3, 4 and 8 wherever the data bit is one and that byte is enabled. Status bits 6 (presence) and 7 (interlock) are never changed by status writes.
- R4: Setting an event bit that is already set produces no new message or interrupt transition.
- R5: A control write with bit 11 set in an enabled byte toggles status bit 7 (interlock engaged). Control bit 11 always reads zero.
- R6: A removal occurs when a card is present and a control write makes the slot "off". Off means bit 10 = 1 (power off) and indicator bits 9:8 = 11. The state before the write must not have been off. A removal clears presence (status bit 6), sets presence-changed (bit 3), clears `dll_active_o` and pulses `remove_o` for one cycle.
- R7: Every control write sets command-completed (status bit 4) in the cycle after the write, in state ST_CMD.
- R8: A card insertion while no card is present sets presence, `dll_active_o`, presence-changed and button-pressed together. An insertion while a card is present is ignored.
- R9: Reset clears all control bits except the following. The attention indicator (bits 7:6) becomes 11 (off), and bits 10 and 9:8 take the values given in R10. Reset clears the interlock, command-completed, presence-changed and button bits.
- R10: With a power controller, reset samples `slot_populated_i`. If it is 1: power on (bit 10 = 0), power indicator 01 (on), presence and `dll_active_o` set. If it is 0: power off (bit 10 = 1), indicator 11 (off), presence and `dll_active_o` clear. `slot_pwr_o` is the inverse of bit 10.
- R11: An unplug request is refused when the power indicator is 10 (blinking) or the interlock is engaged. A refusal gives a one-cycle `unplug_err_o` and changes no state. If the request is accepted, the slot is off and a card is present, the request performs a removal and clears button-pressed. If it is accepted in any other case, it sets button-pressed.
- R12: Control writes change only the bytes whose enable is set. Reserved bits 15:13 read zero.
- R13: An attention-button pulse sets status bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| slot_populated_i | input | 1 | Card present at reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 1 | 0 selects slot control, 1 selects slot status |
| wr_data_i | input | 16 | Write data |
| wr_be_i | input | 2 | Byte enables (bit 0 = bits 7:0) |
| card_insert_i | input | 1 | Card insertion pulse |
| button_i | input | 1 | Attention button pulse |
| unplug_req_i | input | 1 | Unplug request pulse |
| msg_mode_i | input | 1 | 1 selects message signalling |
| vec_i | input | VEC_W | Message vector number |
| ctl_o | output | 16 | Slot control readback |
| sts_o | output | 16 | Slot status readback |
| slot_pwr_o | output | 1 | Slot power enable |
| dll_active_o | output | 1 | Data-link-layer active flag |
| intx_o | output | 1 | Level interrupt wire |
| msg_valid_o | output | 1 | Message request pulse |
| msg_vec_o | output | VEC_W | Vector sent with the message |
| remove_o | output | 1 | Device-removal strobe |
| unplug_err_o | output | 1 | Refused unplug request pulse |

## Verification
Some properties are checked on every cycle. Any control write leads to command-completed one cycle later. A removal strobe always coincides with cleared presence, set presence-changed and a dropped link flag, and never repeats on the next cycle. The wire and the message vector follow the interrupt enable and the vector input. Only the bench scenarios can show the rest: the exact bit values after each control write pattern, partial byte writes, the refusal cases of an unplug request, suppression of duplicate notifications, and both reset variants.

// File: rtl/hp_slot_pkg.sv
package hp_slot_pkg;

    typedef enum logic [1:0] {
        IND_RSVD  = 2'b00,
        IND_ON    = 2'b01,
        IND_BLINK = 2'b10,
        IND_OFF   = 2'b11
    } ind_t;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_CMD  = 1'b1
    } cmd_state_t;

    localparam int REG_W = 16;
    localparam int N_EV  = 6;

    // status bit positions
    localparam int S_ABP  = 0;
    localparam int S_PDC  = 3;
    localparam int S_CC   = 4;
    localparam int S_PDS  = 6;
    localparam int S_EIS  = 7;

    // control bit positions
    localparam int C_HPIE = 5;
    localparam int C_AIL  = 6;
    localparam int C_PIL  = 8;
    localparam int C_PCC  = 10;
    localparam int C_EIC  = 11;

    localparam logic [REG_W-1:0] STS_EVENTS = 16'h011F;

    function automatic int ev_sts_bit(input int i);
        return (i == N_EV - 1) ? 8 : i;
    endfunction

    function automatic int ev_ctl_bit(input int i);
        return (i == N_EV - 1) ? 12 : i;
    endfunction

endpackage

// File: rtl/hp_slot_cmd_fsm.sv
module hp_slot_cmd_fsm
    import hp_slot_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ctl_wr_i,
    output logic apply_o
);

    cmd_state_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (ctl_wr_i) state_d = ST_CMD;
            ST_CMD:  state_d = ctl_wr_i ? ST_CMD : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        apply_o = (state_q == ST_CMD);
    end

    // R7: a control write is always followed by a command-apply cycle
    p_cmd_follows_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_wr_i |=> apply_o);

endmodule

// File: rtl/hp_slot_irq.sv
module hp_slot_irq
    import hp_slot_pkg::*;
#(
    parameter int VEC_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [REG_W-1:0] sts_i,
    input  logic [REG_W-1:0] ctl_i,
    input  logic             msg_mode_i,
    input  logic [VEC_W-1:0] vec_i,
    output logic             intx_o,
    output logic             msg_valid_o,
    output logic [VEC_W-1:0] msg_vec_o
);

    logic [N_EV-1:0] hits;

    for (genvar g = 0; g < N_EV; g++) begin : g_ev
        assign hits[g] = sts_i[ev_sts_bit(g)] & ctl_i[ev_ctl_bit(g)];
    end

    logic cond;
    assign cond = ctl_i[C_HPIE] & (|hits);

    logic             level_q;
    logic             msg_q;
    logic [VEC_W-1:0] vec_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level_q <= 1'b0;
            msg_q   <= 1'b0;
            vec_q   <= '0;
        end else begin
            level_q <= cond;
            msg_q   <= msg_mode_i & (cond != level_q);
            if (cond != level_q) vec_q <= vec_i;
        end
    end

    assign intx_o      = level_q & ~msg_mode_i;
    assign msg_valid_o = msg_q;
    assign msg_vec_o   = vec_q;

    // R1: the wire can only be high if interrupts were enabled a cycle earlier
    p_intx_needs_enable_r1: assert property (@(posedge clk) disable iff (!rst_n)
        intx_o |-> $past(ctl_i[C_HPIE]));

    // R2: a message carries the vector presented in the cycle of the change
    p_msg_vector_r2: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid_o |-> (msg_vec_o == $past(vec_i)));

endmodule

// File: rtl/hp_slot_ctrl.sv
module hp_slot_ctrl
    import hp_slot_pkg::*;
#(
    parameter int VEC_W   = 5,
    parameter bit PWR_CTL = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             slot_populated_i,
    input  logic             wr_en_i,
    input  logic             wr_sel_i,
    input  logic [15:0]      wr_data_i,
    input  logic [1:0]       wr_be_i,
    input  logic             card_insert_i,
    input  logic             button_i,
    input  logic             unplug_req_i,
    input  logic             msg_mode_i,
    input  logic [VEC_W-1:0] vec_i,
    output logic [15:0]      ctl_o,
    output logic [15:0]      sts_o,
    output logic             slot_pwr_o,
    output logic             dll_active_o,
    output logic             intx_o,
    output logic             msg_valid_o,
    output logic [VEC_W-1:0] msg_vec_o,
    output logic             remove_o,
    output logic             unplug_err_o
);

    localparam logic [REG_W-1:0] CTL_WMASK = PWR_CTL ? 16'h17FF : 16'h13FF;

    logic [REG_W-1:0] ctl_q, sts_q;
    logic             dll_q, rm_pend_q, eic_pend_q, remove_q, err_q;
    logic             apply;

    // ---------------- write decode ----------------
    logic [REG_W-1:0] be_mask, ctl_new, ctl_rst;
    logic             ctl_wr, sts_wr, off_now, off_before, eic_hit;

    assign be_mask = {{8{wr_be_i[1]}}, {8{wr_be_i[0]}}};
    assign ctl_wr  = wr_en_i & ~wr_sel_i;
    assign sts_wr  = wr_en_i &  wr_sel_i;
    assign ctl_new = (ctl_q & ~(be_mask & CTL_WMASK)) | (wr_data_i & be_mask & CTL_WMASK);
    assign eic_hit = wr_data_i[C_EIC] & wr_be_i[1];

    function automatic logic slot_off(input logic [REG_W-1:0] c);
        return c[C_PCC] & (c[C_PIL+1:C_PIL] == IND_OFF);
    endfunction

    assign off_now    = slot_off(ctl_new);
    assign off_before = slot_off(ctl_q);

    always_comb begin
        ctl_rst = '0;
        ctl_rst[C_AIL+1:C_AIL] = IND_OFF;
        if (PWR_CTL) begin
            ctl_rst[C_PCC]         = ~slot_populated_i;
            ctl_rst[C_PIL+1:C_PIL] = slot_populated_i ? IND_ON : IND_OFF;
        end
    end

    // ---------------- unplug request ----------------
    logic refuse, un_rm, un_abp;
    assign refuse = (ctl_q[C_PIL+1:C_PIL] == IND_BLINK) | sts_q[S_EIS];
    assign un_rm  = ~refuse & off_before & sts_q[S_PDS];
    assign un_abp = ~refuse & ~un_rm;

    // ---------------- status next state ----------------
    logic [REG_W-1:0] sts_d;
    logic             dll_d, do_rm;

    assign do_rm = (apply & rm_pend_q & sts_q[S_PDS]) | (unplug_req_i & un_rm);

    always_comb begin
        sts_d = sts_q;
        dll_d = dll_q;
        if (sts_wr) sts_d = sts_d & ~(wr_data_i & be_mask & STS_EVENTS);
        if (apply & eic_pend_q) sts_d[S_EIS] = ~sts_q[S_EIS];
        if (apply) sts_d[S_CC] = 1'b1;
        if (button_i | (unplug_req_i & un_abp)) sts_d[S_ABP] = 1'b1;
        if (do_rm) begin
            sts_d[S_PDS] = 1'b0;
            sts_d[S_PDC] = 1'b1;
            dll_d        = 1'b0;
        end
        if (unplug_req_i & un_rm) sts_d[S_ABP] = 1'b0;
        if (card_insert_i & ~sts_q[S_PDS] & ~do_rm) begin
            sts_d[S_PDS] = 1'b1;
            sts_d[S_PDC] = 1'b1;
            sts_d[S_ABP] = 1'b1;
            dll_d        = 1'b1;
        end
    end

    // ---------------- registers ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q      <= ctl_rst;
            sts_q      <= '0;
            sts_q[S_PDS] <= PWR_CTL ? slot_populated_i : 1'b0;
            dll_q      <= PWR_CTL ? slot_populated_i : 1'b0;
            rm_pend_q  <= 1'b0;
            eic_pend_q <= 1'b0;
            remove_q   <= 1'b0;
            err_q      <= 1'b0;
        end else begin
            sts_q    <= sts_d;
            dll_q    <= dll_d;
            remove_q <= do_rm;
            err_q    <= unplug_req_i & refuse;
            if (ctl_wr) begin
                ctl_q      <= ctl_new;
                rm_pend_q  <= off_now & ~off_before;
                eic_pend_q <= eic_hit;
            end else if (apply) begin
                rm_pend_q  <= 1'b0;
                eic_pend_q <= 1'b0;
            end
        end
    end

    // ---------------- submodules ----------------
    hp_slot_cmd_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctl_wr_i (ctl_wr),
        .apply_o  (apply)
    );

    hp_slot_irq #(.VEC_W(VEC_W)) u_irq (
        .clk         (clk),
        .rst_n       (rst_n),
        .sts_i       (sts_q),
        .ctl_i       (ctl_q),
        .msg_mode_i  (msg_mode_i),
        .vec_i       (vec_i),
        .intx_o      (intx_o),
        .msg_valid_o (msg_valid_o),
        .msg_vec_o   (msg_vec_o)
    );

    assign ctl_o        = ctl_q;
    assign sts_o        = sts_q;
    assign dll_active_o = dll_q;
    assign slot_pwr_o   = PWR_CTL ? ~ctl_q[C_PCC] : 1'b1;
    assign remove_o     = remove_q;
    assign unplug_err_o = err_q;

    // R7: command-completed is set after every apply cycle
    p_cc_after_cmd_r7: assert property (@(posedge clk) disable iff (!rst_n)
        apply |=> sts_q[S_CC]);

    // R6: the removal strobe coincides with the removed-slot status
    p_removal_state_r6: assert property (@(posedge clk) disable iff (!rst_n)
        remove_o |-> (!sts_q[S_PDS] && sts_q[S_PDC] && !dll_active_o));

    // R6: a removal is a single pulse
    p_removal_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        remove_o |=> !remove_o);

endmodule

// File: tb/hp_slot_ctrl_bench.sv
module hp_slot_ctrl_bench;

    localparam int CLK_PERIOD = 10;
    localparam int VEC_W      = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic populated = 1'b1;
    logic wr_en = 1'b0, wr_sel = 1'b0;
    logic [15:0] wr_data = '0;
    logic [1:0]  wr_be = '0;
    logic card_insert = 1'b0, button = 1'b0, unplug = 1'b0, msg_mode = 1'b0;
    logic [VEC_W-1:0] vec = '0;
    logic [15:0] ctl, sts;
    logic slot_pwr, dll, intx, msg_valid, remove, uerr;
    logic [VEC_W-1:0] msg_vec;

    always #(CLK_PERIOD/2) clk = ~clk;

    hp_slot_ctrl #(.VEC_W(VEC_W)) u_hp_slot_ctrl (
        .clk(clk), .rst_n(rst_n), .slot_populated_i(populated),
        .wr_en_i(wr_en), .wr_sel_i(wr_sel), .wr_data_i(wr_data), .wr_be_i(wr_be),
        .card_insert_i(card_insert), .button_i(button), .unplug_req_i(unplug),
        .msg_mode_i(msg_mode), .vec_i(vec),
        .ctl_o(ctl), .sts_o(sts), .slot_pwr_o(slot_pwr), .dll_active_o(dll),
        .intx_o(intx), .msg_valid_o(msg_valid), .msg_vec_o(msg_vec),
        .remove_o(remove), .unplug_err_o(uerr)
    );

    int checks = 0, failures = 0, msg_cnt = 0, rm_cnt = 0;
    bit done = 0;

    always @(negedge clk) begin
        if (rst_n && msg_valid) msg_cnt++;
        if (rst_n && remove)    rm_cnt++;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic reg_wr(input logic sel, input logic [15:0] d, input logic [1:0] be);
        wr_en = 1'b1; wr_sel = sel; wr_data = d; wr_be = be;
        @(negedge clk);
        wr_en = 1'b0; wr_be = '0;
    endtask

    task automatic pulse_insert();
        card_insert = 1'b1; @(negedge clk); card_insert = 1'b0;
    endtask
    task automatic pulse_button();
        button = 1'b1; @(negedge clk); button = 1'b0;
    endtask
    task automatic pulse_unplug();
        unplug = 1'b1; @(negedge clk); unplug = 1'b0;
    endtask

    // data, byte enables, expected control, expected status after apply
    localparam logic [15:0] TBL [0:5][0:3] = '{
        '{16'h0020, 16'h0003, 16'h0020, 16'h0050},
        '{16'h0820, 16'h0003, 16'h0020, 16'h00D0},
        '{16'h0820, 16'h0003, 16'h0020, 16'h0050},
        '{16'h02C0, 16'h0001, 16'h00C0, 16'h0050},
        '{16'h0B00, 16'h0002, 16'h03C0, 16'h00D0},
        '{16'h07C0, 16'h0003, 16'h07C0, 16'h0098}
    };

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=%h expected=%h", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int m0;
        tick(); tick();
        rst_n = 1'b1;
        tick();
        // R9 / R10: reset with a populated slot
        check("R9 ctl reset", ctl, 16'h01C0);
        check("R9 sts reset", sts, 16'h0040);
        check("R10 power on", slot_pwr, 1'b1);
        check("R10 dll set", dll, 1'b1);
        check("R2 intx idle", intx, 1'b0);

        // table walk: R5 R7 R12 R6
        for (int i = 0; i < 6; i++) begin
            reg_wr(1'b0, TBL[i][0], TBL[i][1][1:0]);
            tick();
            check($sformatf("R12 ctl row %0d", i), ctl, TBL[i][2]);
            check($sformatf("R7 R5 sts row %0d", i), sts, TBL[i][3]);
            reg_wr(1'b1, 16'h011F, 2'b11);
        end
        check("R6 remove count", rm_cnt, 1);
        check("R6 dll cleared", dll, 1'b0);
        check("R10 power follows ctl", slot_pwr, 1'b0);
        check("R3 W1C keeps interlock", sts, 16'h0080);

        // R11: refused while interlock engaged
        pulse_unplug();
        check("R11 err on interlock", uerr, 1'b1);
        check("R11 no change", sts, 16'h0080);
        reg_wr(1'b0, 16'h0FC0, 2'b11); tick();
        check("R5 interlock off", sts, 16'h0010);
        check("R6 no removal when already off", rm_cnt, 1);
        reg_wr(1'b1, 16'h0010, 2'b11);

        // R8: insertion
        pulse_insert();
        check("R8 insert sts", sts, 16'h0049);
        check("R8 insert dll", dll, 1'b1);
        reg_wr(1'b1, 16'h011F, 2'b11);
        pulse_insert();
        check("R8 insert while present ignored", sts, 16'h0040);

        // R11: accepted while off with a card present -> removal
        pulse_unplug();
        check("R11 unplug removal sts", sts, 16'h0008);
        check("R11 remove strobe", remove, 1'b1);
        check("R11 no err", uerr, 1'b0);
        reg_wr(1'b1, 16'h011F, 2'b11);
        pulse_insert();
        reg_wr(1'b1, 16'h011F, 2'b11);

        // R11: refused while blinking
        reg_wr(1'b0, 16'h0220, 2'b11); tick();
        reg_wr(1'b1, 16'h011F, 2'b11);
        pulse_unplug();
        check("R11 err on blink", uerr, 1'b1);
        check("R11 blink no change sts", sts, 16'h0040);
        check("R11 blink no change ctl", ctl, 16'h0220);

        // R11: accepted otherwise -> button event
        reg_wr(1'b0, 16'h0100, 2'b11); tick();
        reg_wr(1'b1, 16'h011F, 2'b11);
        pulse_unplug();
        check("R11 unplug sets button", sts, 16'h0041);
        reg_wr(1'b1, 16'h011F, 2'b11);

        // R13 and R3 byte enables
        pulse_button();
        check("R13 button", sts, 16'h0041);
        reg_wr(1'b1, 16'h0001, 2'b10);
        check("R3 disabled byte keeps bit", sts, 16'h0041);
        reg_wr(1'b1, 16'h0001, 2'b01);
        check("R3 enabled byte clears", sts, 16'h0040);
        reg_wr(1'b1, 16'h00C0, 2'b11);
        check("R3 presence not clearable", sts, 16'h0040);

        // R1 / R2: level interrupt on command completed
        reg_wr(1'b0, 16'h0130, 2'b11);
        tick();
        check("R2 intx lags condition", intx, 1'b0);
        tick();
        check("R1 intx raised", intx, 1'b1);
        reg_wr(1'b1, 16'h0010, 2'b11);
        check("R2 intx lags clear", intx, 1'b1);
        tick();
        check("R1 intx dropped", intx, 1'b0);
        pulse_button(); tick();
        check("R1 disabled event no irq", intx, 1'b0);
        reg_wr(1'b1, 16'h011F, 2'b11);

        // R2 / R4: message signalling
        msg_mode = 1'b1; vec = 5'd9;
        tick();
        m0 = msg_cnt;
        reg_wr(1'b0, 16'h0130, 2'b11);
        tick(); tick();
        check("R2 msg pulse", msg_valid, 1'b1);
        check("R2 msg vector", msg_vec, 5'd9);
        check("R2 wire quiet", intx, 1'b0);
        tick();
        check("R2 msg single", msg_valid, 1'b0);
        reg_wr(1'b0, 16'h0130, 2'b11);
        tick(); tick(); tick();
        check("R4 no repeat msg", msg_cnt - m0, 1);
        vec = 5'd3;
        reg_wr(1'b1, 16'h0010, 2'b11);
        tick(); tick();
        check("R2 msg on fall", msg_cnt - m0, 2);
        check("R2 fall vector", msg_vec, 5'd3);

        // R9 / R10: reset with an empty slot
        rst_n = 1'b0; populated = 1'b0;
        tick(); tick();
        rst_n = 1'b1;
        tick();
        check("R10 empty ctl", ctl, 16'h07C0);
        check("R9 empty sts", sts, 16'h0000);
        check("R10 empty power off", slot_pwr, 1'b0);
        check("R10 empty dll", dll, 1'b0);
        check("R9 msg idle", msg_valid, 1'b0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule